// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a 128K x 8 serial memory. It runs on a fast system clock and oversamples the raw two-wire clock and data lines. It finds Start and Stop conditions and decodes the control byte against its chip-select pins. It then collects a 16-bit word address or serves read data from a synchronous memory read port. Received write bytes, each with the address it belongs to, go to a separate page-write block. That block also reports through a busy input that control bytes must not be acknowledged.

An internal 17-bit pointer tracks the next address. The block-select bit of the control byte supplies pointer bit 16. Read increments wrap inside the selected 64K half. Write increments wrap inside one page of 2^PAGE_BITS bytes. SDA is driven open-drain through a single pull-low enable. A change to it waits a programmable number of system clocks after the detected SCL falling edge.

The write stream follows valid/ready rules with no stalling. `wr_valid_o` is high for exactly one cycle per received data byte. The byte counts as transferred only if `wr_ready_i` is high in that same cycle. A refused byte is not acknowledged on the bus, and the block ignores the rest of that command. The read port has no handshake. `rd_en_o` is a one-cycle request for `rd_addr_o`, and `rd_data_i` must be valid from the following cycle until the next request.

Top module: `sm_i2c_slave`

## Requirements
- R1: A Start (SDA falling while SCL is high) in any state aborts the current transfer and restarts control-byte reception; a Stop (SDA rising while SCL is high) returns the block to idle; an aborted address phase leaves the pointer unchanged.
- R2: The control byte is received MSB first as bits [7:4] device code 1010, [3] block select, [2:1] chip select compared with `cs_sel_i[1:0]`, [0] direction (1 = read). The block acknowledges by pulling SDA low in the ninth clock only when code and chip select both match; otherwise SDA stays released and the block waits for the next Start.
- R3: While `sel_fixed_i` is low, no control byte is acknowledged.
- R4: After an acknowledged write control byte, the next two bytes are acknowledged and taken as address bits [15:8] then [7:0]; the pointer becomes {block select, high byte, low byte}.
- R5: Each later data byte is offered on the write stream with its address and data; `wr_first_o` marks the first byte after the address. `wr_valid_o` lasts one cycle. After an accepted byte, the low PAGE_BITS of the pointer increment and wrap within the page.
- R6: A data byte offered while `wr_ready_i` is low is not acknowledged and not transferred.
- R7: `wr_commit_o` pulses one cycle after a Stop when the command transferred at least one data byte; an address-only write (random-read setup) or a repeated Start gives no commit.
- R8: A read control byte returns the byte at the pointer, after which the pointer is one higher (current-address read).
- R9: A write control byte with two address bytes, then a repeated Start and a read control byte, returns the byte at the loaded address and writes nothing.
- R10: In a read, a master ACK (SDA low in the ninth clock) makes the block send the next byte; a master NACK leaves SDA released.
- R11: Read increments change only pointer bits [15:0]: FFFFh is followed by 0000h and 1FFFFh by 10000h.
- R12: SDA enable changes occur only while SCL is low, at least HOLD_CYC system clocks after the detected SCL fall.
- R13: While `busy_i` is high, no control byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen on the wire |
| cs_sel_i | input | 2 | Chip-select pins compared with control bits [2:1] |
| sel_fixed_i | input | 1 | Fixed select; must be high for any response |
| busy_i | input | 1 | Internal write cycle running; inhibits control acknowledge |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_valid_o | output | 1 | One-cycle offer of a received write byte |
| wr_ready_i | input | 1 | Write sink can take the offered byte |
| wr_addr_o | output | 17 | Address of the offered byte |
| wr_data_o | output | 8 | Offered byte |
| wr_first_o | output | 1 | Offered byte is the first of its command |
| wr_commit_o | output | 1 | One-cycle pulse: start the write cycle |
| rd_en_o | output | 1 | One-cycle memory read request |
| rd_addr_o | output | 17 | Memory read address |
| rd_data_i | input | 8 | Memory read data, valid the cycle after the request |

## Verification
A wrong pointer shows up as the wrong byte in the next read, in the very bit period that byte is shifted out. A stale pointer after a write, a wrap into the other half, or a pointer loaded from an aborted address phase each give a specific expected value. A broken bit counter or state moves the ninth-clock acknowledge and is seen within one byte, as a missing ACK or a data bit in the wrong place. Write-stream items are matched in order against a scoreboard as they appear. Commit pulses are counted against the Stops that should produce them.

// File: rtl/sm_i2c_pkg.sv
package sm_i2c_pkg;
  localparam int SM_ADDR_W = 17;
  localparam int SM_BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } sm_state_e;
endpackage

// File: rtl/sm_bus_sync.sv
module sm_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic              scl_h, sda_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_h <= 1'b1;
      sda_h <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_h <= scl_p[STAGES-1];
      sda_h <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_h;
  assign scl_fall  = ~scl_s & scl_h;
  assign start_evt = scl_s & scl_h & sda_h & ~sda_s;
  assign stop_evt  = scl_s & scl_h & ~sda_h & sda_s;
endmodule

// File: rtl/sm_addr_ptr.sv
module sm_addr_ptr #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_rd,
  input  logic              inc_wr,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HALF_BITS = ADDR_W - 1;

  logic [ADDR_W-1:0] nxt_rd, nxt_wr;

  // read increment stays within the current half
  assign nxt_rd = {ptr[ADDR_W-1], ptr[HALF_BITS-1:0] + 1'b1};
  // write increment stays within the current page
  assign nxt_wr = {ptr[ADDR_W-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (load)   ptr <= load_val;
    else if (inc_rd) ptr <= nxt_rd;
    else if (inc_wr) ptr <= nxt_wr;
  end
endmodule

// File: rtl/sm_sda_hold.sv
module sm_sda_hold #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  input  logic force_rel,
  input  logic target_low,
  output logic pull_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pull_o <= 1'b0;
    end else if (force_rel) begin
      cnt    <= '0;
      pull_o <= 1'b0;
    end else if (scl_fall) begin
      cnt <= CW'(HOLD_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) pull_o <= target_low;
    end
  end
endmodule

// File: rtl/sm_i2c_slave.sv
module sm_i2c_slave
  import sm_i2c_pkg::*;
#(
  parameter int          PAGE_BITS   = 7,
  parameter int          HOLD_CYC    = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [1:0]           cs_sel_i,
  input  logic                 sel_fixed_i,
  input  logic                 busy_i,
  output logic                 sda_pull_o,
  output logic                 wr_valid_o,
  input  logic                 wr_ready_i,
  output logic [SM_ADDR_W-1:0] wr_addr_o,
  output logic [SM_BYTE_W-1:0] wr_data_o,
  output logic                 wr_first_o,
  output logic                 wr_commit_o,
  output logic                 rd_en_o,
  output logic [SM_ADDR_W-1:0] rd_addr_o,
  input  logic [SM_BYTE_W-1:0] rd_data_i
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  sm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  sm_state_e           state;
  logic [3:0]          bitcnt;
  logic                in_ack;
  logic [SM_BYTE_W-1:0] shreg, tx_q, addr_hi;
  logic                b0_q, rw_q, ack_q, mack_q;
  logic                target_low, first_q, acc_any;

  logic                byte_done, ack_end, ctrl_ok, rx_ack_ok;
  logic                ptr_ld, inc_rd, inc_wr;
  logic [SM_ADDR_W-1:0] ptr;

  assign byte_done = scl_fall && !in_ack && (bitcnt == BITS_PER_BYTE);
  assign ack_end   = scl_fall && in_ack;

  assign ctrl_ok = (shreg[7:4] == DEV_CODE) && (shreg[2:1] == cs_sel_i)
                   && sel_fixed_i && !busy_i;

  always_comb begin
    case (state)
      ST_CTRL: rx_ack_ok = ctrl_ok;
      ST_WDAT: rx_ack_ok = wr_ready_i;
      default: rx_ack_ok = 1'b1;
    endcase
  end

  assign ptr_ld = (state == ST_ALO) && byte_done;
  assign inc_wr = wr_valid_o && wr_ready_i;
  assign inc_rd = ack_end && (((state == ST_CTRL) && ack_q && rw_q) ||
                              ((state == ST_RDAT) && mack_q));

  sm_addr_ptr #(.ADDR_W(SM_ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_ld),
    .load_val ({b0_q, addr_hi, shreg}),
    .inc_rd   (inc_rd),
    .inc_wr   (inc_wr),
    .ptr      (ptr)
  );

  assign wr_valid_o = (state == ST_WDAT) && byte_done;
  assign wr_addr_o  = ptr;
  assign wr_data_o  = shreg;
  assign wr_first_o = first_q;
  assign rd_addr_o  = ptr;
  assign rd_en_o    = ((state == ST_CTRL) && byte_done && ctrl_ok && shreg[0]) ||
                      ((state == ST_RDAT) && scl_rise && in_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bitcnt      <= '0;
      in_ack      <= 1'b0;
      shreg       <= '0;
      tx_q        <= '0;
      addr_hi     <= '0;
      b0_q        <= 1'b0;
      rw_q        <= 1'b0;
      ack_q       <= 1'b0;
      mack_q      <= 1'b0;
      target_low  <= 1'b0;
      first_q     <= 1'b0;
      acc_any     <= 1'b0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_commit_o <= 1'b0;
      if (start_evt) begin
        state      <= ST_CTRL;
        bitcnt     <= '0;
        in_ack     <= 1'b0;
        target_low <= 1'b0;
        acc_any    <= 1'b0;
      end else if (stop_evt) begin
        state       <= ST_IDLE;
        bitcnt      <= '0;
        in_ack      <= 1'b0;
        target_low  <= 1'b0;
        wr_commit_o <= acc_any;
        acc_any     <= 1'b0;
      end else if (state == ST_RDAT) begin
        if (scl_rise && in_ack) mack_q <= ~sda_s;
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            if (mack_q) begin
              tx_q       <= rd_data_i;
              target_low <= ~rd_data_i[7];
            end else begin
              state      <= ST_IDLE;
              target_low <= 1'b0;
            end
          end else if (bitcnt < 4'd7) begin
            bitcnt     <= bitcnt + 4'd1;
            tx_q       <= {tx_q[6:0], 1'b0};
            target_low <= ~tx_q[6];
          end else begin
            in_ack     <= 1'b1;
            target_low <= 1'b0;
          end
        end
      end else if (state != ST_IDLE) begin
        if (scl_rise && !in_ack && (bitcnt < BITS_PER_BYTE)) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
        if (byte_done) begin
          in_ack     <= 1'b1;
          ack_q      <= rx_ack_ok;
          target_low <= rx_ack_ok;
          case (state)
            ST_CTRL: if (ctrl_ok) begin
              b0_q <= shreg[3];
              rw_q <= shreg[0];
            end
            ST_AHI:  addr_hi <= shreg;
            ST_ALO:  first_q <= 1'b1;
            ST_WDAT: if (wr_ready_i) begin
              first_q <= 1'b0;
              acc_any <= 1'b1;
            end
            default: ;
          endcase
        end else if (ack_end) begin
          in_ack     <= 1'b0;
          bitcnt     <= '0;
          target_low <= 1'b0;
          if (!ack_q) begin
            state <= ST_IDLE;
          end else begin
            case (state)
              ST_CTRL: if (rw_q) begin
                state      <= ST_RDAT;
                tx_q       <= rd_data_i;
                target_low <= ~rd_data_i[7];
              end else begin
                state <= ST_AHI;
              end
              ST_AHI:  state <= ST_ALO;
              ST_ALO:  state <= ST_WDAT;
              default: ;
            endcase
          end
        end
      end
    end
  end

  sm_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_fall   (scl_fall),
    .force_rel  (start_evt | stop_evt),
    .target_low (target_low),
    .pull_o     (sda_pull_o)
  );
endmodule

// File: rtl/sm_i2c_checker.sv
module sm_i2c_checker #(
  parameter int HOLD_CYC = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_pull_o,
  input logic        scl_s,
  input logic        scl_fall,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        wr_valid_o,
  input logic        wr_commit_o,
  input logic        rd_en_o,
  input logic [16:0] rd_addr_o,
  input logic        sel_fixed_i
);
  localparam int SW = $clog2(HOLD_CYC + 2) + 1;
  localparam logic [SW-1:0] SF_MAX = SW'(HOLD_CYC + 1);

  logic [SW-1:0] since_fall;
  logic          rd_seen, half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_fall <= SF_MAX;
      rd_seen    <= 1'b0;
      half_q     <= 1'b0;
    end else begin
      if (scl_fall) since_fall <= '0;
      else if (since_fall != SF_MAX) since_fall <= since_fall + 1'b1;
      if (start_evt) rd_seen <= 1'b0;
      else if (rd_en_o) begin
        rd_seen <= 1'b1;
        half_q  <= rd_addr_o[16];
      end
    end
  end

  // R12: SDA enable holds for HOLD_CYC clocks after a detected SCL fall
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (since_fall < SW'(HOLD_CYC)) && !$past(start_evt || stop_evt) |-> $stable(sda_pull_o));

  // R12: SDA enable only moves while SCL is low
  p_change_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) && !$past(start_evt || stop_evt) |-> !scl_s);

  // R5: write offer lasts one cycle
  p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  // R7: commit follows a Stop
  p_commit_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_evt));

  // R11: reads within one transfer stay in one half
  p_half_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o && rd_seen |-> rd_addr_o[16] == half_q);

  // R3: no pull-down starts without the fixed select
  p_fixed_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> sel_fixed_i);
endmodule

bind sm_i2c_slave sm_i2c_checker #(.HOLD_CYC(HOLD_CYC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_pull_o  (sda_pull_o),
  .scl_s       (scl_s),
  .scl_fall    (scl_fall),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .wr_valid_o  (wr_valid_o),
  .wr_commit_o (wr_commit_o),
  .rd_en_o     (rd_en_o),
  .rd_addr_o   (rd_addr_o),
  .sel_fixed_i (sel_fixed_i)
);

// File: tb/sm_i2c_slave_tb_top.sv
module sm_i2c_slave_tb_top;
  localparam int Q    = 16;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] cs_sel = 2'b10;
  logic sel_fixed = 1'b1, busy = 1'b0, wr_ready = 1'b1;
  logic [7:0] rd_data = '0;
  logic sda_pull, wr_valid, wr_first, wr_commit, rd_en;
  logic [16:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  wire sda_line = m_sda & ~sda_pull;

  sm_i2c_slave #(.HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .cs_sel_i(cs_sel), .sel_fixed_i(sel_fixed), .busy_i(busy),
    .sda_pull_o(sda_pull), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_first_o(wr_first),
    .wr_commit_o(wr_commit), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data)
  );

  function automatic logic [7:0] mem_f(input logic [16:0] a);
    return a[7:0] ^ {a[15:9], a[16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_f(rd_addr);

  int n_chk = 0, n_fail = 0, commits = 0;
  bit done = 0;
  logic [25:0] exp_q[$];
  logic [25:0] got_item, exp_item;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // scoreboard monitor for the write stream
  always @(negedge clk) if (rst_n && !done) begin
    if (wr_valid && wr_ready) begin
      got_item = {wr_first, wr_addr, wr_data};
      if (exp_q.size() == 0) chk(0, "R5 unexpected write item", {6'd0, got_item}, 0);
      else begin
        exp_item = exp_q.pop_front();
        chk(got_item == exp_item, "R5 write item", {6'd0, got_item}, {6'd0, exp_item});
      end
    end
    if (wr_commit) commits++;
  end

  // hold-time monitor
  int cyc = 0, last_fall = 0, min_gap = 1000, n_changes = 0;
  logic scl_prev = 1'b1, pull_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (scl_prev && !m_scl) last_fall = cyc;
    if (rst_n && (sda_pull !== pull_prev)) begin
      n_changes++;
      if (m_scl) min_gap = 0;
      else if (cyc - last_fall < min_gap) min_gap = cyc - last_fall;
    end
    scl_prev  = m_scl;
    pull_prev = sda_pull;
  end

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_bit);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2 * Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack_bit = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] ctl(input logic b0, input logic [1:0] cs, input logic rw);
    return {4'b1010, b0, cs, rw};
  endfunction

  task automatic set_addr(input logic b0, input logic [15:0] a, input string req);
    logic ak;
    send_byte(ctl(b0, 2'b10, 1'b0), ak); chk(ak == 1'b0, req, ak, 0);
    send_byte(a[15:8], ak);              chk(ak == 1'b0, "R4 high address ack", ak, 0);
    send_byte(a[7:0], ak);               chk(ak == 1'b0, "R4 low address ack", ak, 0);
  endtask

  logic ak;
  logic [7:0] rb;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_pull == 1'b0 && wr_valid == 1'b0 && rd_en == 1'b0, "R1 reset outputs idle",
        {sda_pull, wr_valid, rd_en}, 0);

    // R4 R5: page write at 1_237E with wrap inside the page
    exp_q.push_back({1'b1, 17'h1237E, 8'hC1});
    exp_q.push_back({1'b0, 17'h1237F, 8'h3D});
    exp_q.push_back({1'b0, 17'h12300, 8'h96});
    i2c_start();
    set_addr(1'b1, 16'h237E, "R2 write control ack");
    send_byte(8'hC1, ak); chk(ak == 1'b0, "R5 data ack", ak, 0);
    send_byte(8'h3D, ak); chk(ak == 1'b0, "R5 data ack", ak, 0);
    send_byte(8'h96, ak); chk(ak == 1'b0, "R5 data ack", ak, 0);
    i2c_stop();
    tick(4);
    chk(commits == 1, "R7 commit after write", commits, 1);

    // R8: current-address read after the write
    i2c_start();
    send_byte(ctl(1'b1, 2'b10, 1'b1), ak); chk(ak == 1'b0, "R8 read control ack", ak, 0);
    recv_byte(1'b0, rb);
    chk(rb == mem_f(17'h12301), "R8 current address byte", rb, mem_f(17'h12301));
    chk(sda_pull == 1'b0, "R10 released after master NACK", sda_pull, 0);
    i2c_stop();

    // R9 R10 R11: random then sequential read across FFFF in half 0
    i2c_start();
    set_addr(1'b0, 16'hFFFE, "R9 write control ack");
    i2c_start();
    send_byte(ctl(1'b0, 2'b10, 1'b1), ak); chk(ak == 1'b0, "R9 read control ack", ak, 0);
    recv_byte(1'b1, rb); chk(rb == mem_f(17'h0FFFE), "R9 random read byte", rb, mem_f(17'h0FFFE));
    recv_byte(1'b1, rb); chk(rb == mem_f(17'h0FFFF), "R10 sequential byte", rb, mem_f(17'h0FFFF));
    recv_byte(1'b0, rb); chk(rb == mem_f(17'h00000), "R11 wrap FFFF to 0000", rb, mem_f(17'h00000));
    i2c_stop();
    tick(4);
    chk(commits == 1, "R7 no commit for address-only write", commits, 1);

    // R11: wrap in the upper half
    i2c_start();
    set_addr(1'b1, 16'hFFFF, "R11 write control ack");
    i2c_start();
    send_byte(ctl(1'b1, 2'b10, 1'b1), ak);
    recv_byte(1'b1, rb); chk(rb == mem_f(17'h1FFFF), "R11 byte at 1FFFF", rb, mem_f(17'h1FFFF));
    recv_byte(1'b0, rb); chk(rb == mem_f(17'h10000), "R11 wrap 1FFFF to 10000", rb, mem_f(17'h10000));
    i2c_stop();

    // R1: address phase aborted by repeated Start leaves pointer at 10001
    i2c_start();
    send_byte(ctl(1'b0, 2'b10, 1'b0), ak);
    send_byte(8'h44, ak);
    i2c_start();
    send_byte(ctl(1'b1, 2'b10, 1'b1), ak); chk(ak == 1'b0, "R1 control after abort ack", ak, 0);
    recv_byte(1'b0, rb); chk(rb == mem_f(17'h10001), "R1 pointer kept after abort", rb, mem_f(17'h10001));
    i2c_stop();

    // R2: chip-select mismatch and wrong device code
    i2c_start();
    send_byte(ctl(1'b0, 2'b01, 1'b0), ak); chk(ak == 1'b1, "R2 chip select mismatch no ack", ak, 1);
    i2c_stop();
    i2c_start();
    send_byte(8'hB4, ak); chk(ak == 1'b1, "R2 wrong device code no ack", ak, 1);
    i2c_stop();

    // R3: fixed select low
    sel_fixed = 1'b0;
    i2c_start();
    send_byte(ctl(1'b0, 2'b10, 1'b1), ak); chk(ak == 1'b1, "R3 fixed select low no ack", ak, 1);
    i2c_stop();
    sel_fixed = 1'b1;

    // R13: busy inhibits acknowledge
    busy = 1'b1;
    i2c_start();
    send_byte(ctl(1'b0, 2'b10, 1'b0), ak); chk(ak == 1'b1, "R13 busy no ack", ak, 1);
    i2c_stop();
    busy = 1'b0;

    // R6: sink not ready
    wr_ready = 1'b0;
    i2c_start();
    set_addr(1'b0, 16'h0100, "R6 write control ack");
    send_byte(8'h77, ak); chk(ak == 1'b1, "R6 refused byte not acked", ak, 1);
    i2c_stop();
    wr_ready = 1'b1;
    tick(4);
    chk(commits == 1, "R6 no commit after refused byte", commits, 1);

    chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    chk(n_changes > 0 && min_gap >= HOLD, "R12 SDA hold after SCL fall", min_gap, HOLD);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule